// File: doc/BRIEF.md
# Bouncing Two-Character Message Scroller

This block steps a text message across a pair of adjacent character positions. The message is held as byte-wide ASCII codes in an external synchronous memory, one character per address, beginning at address 0. On each scroll step the block issues a single read. When the data returns, the character in the right position moves to the left position and the fetched character takes its place on the right.

The message bounces. A reserved end code (0x00) ends the text. When that code is read during a forward scan, the scan turns around and runs toward address 0. It turns forward again once address 0 has been shown. The end code is never placed on either position.

The step period is a run-time speed setting multiplied by a fixed cycle count per unit. Two one-cycle command strobes make the scroll faster or slower. Glyph decoding, command decoding and the memory itself lie outside the block.

Top module: `scroll_msg_ctrl`

## Requirements
- R1: A synchronous reset sets both positions to a space (0x20), the read address to 0, the scan direction to forward, the read strobe low and the speed setting to SPD_INIT (default 8).
- R2: The read strobe is high for exactly one cycle per step. With no speed command in between, consecutive strobes are speed × UNIT_CYC cycles apart.
- R3: In a forward scan, a non-zero byte read from address A shifts the right character into the left position and the new byte into the right position. The next read is then at A+1.
- R4: The end code 0x00 never appears on either position. A step that reads it leaves both positions unchanged.
- R5: The end code read at forward address A ≥ 2 turns the scan to reverse, and the next read is at A−2, so no character appears twice at the turn. At A = 1 the scan turns to reverse with the next read at 0. At A = 0 the scan stays forward at address 0.
- R6: In a reverse scan, a read at address A > 0 is followed by a read at A−1. A read at address 0 turns the scan forward, and the next read is at address 1.
- R7: A forward read of a non-zero byte at the highest address displays it, turns the scan to reverse, and makes the next read at that address minus 1.
- R8: A faster strobe lowers the speed setting by 1, down to a floor of 1. A slower strobe raises it by 1, up to a ceiling of 15. Both strobes together, or neither, leave it unchanged.
- R9: The read address and both positions change only on the second clock edge after a read strobe; they are held at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| faster_i | input | 1 | One-cycle command: shorten the step period |
| slower_i | input | 1 | One-cycle command: lengthen the step period |
| mem_addr_o | output | ADDR_W | Message memory read address |
| mem_rd_o | output | 1 | One-cycle read strobe |
| mem_data_i | input | CHAR_W | Memory read data, valid one cycle after the strobe |
| left_char_o | output | CHAR_W | Character code for the left position |
| right_char_o | output | CHAR_W | Character code for the right position |

## Verification
Directed messages of length 0, 1 and 2 exercise each turnaround case. At the short end of the message, these separate the A−2 rule from the clamped rules, and a memory with no end code at all reaches the top-address turn. Random printable messages of 2 to 30 characters run through several full bounces. They catch sequencing errors that only appear after repeated turns. Speed commands are applied in long runs of one kind, which drive the setting into both limits and show off-by-one errors in the limits. Random mixes of the two commands then show whether the measured step period follows the setting.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
   typedef enum logic {SCAN_FWD = 1'b0, SCAN_REV = 1'b1} scan_dir_e;
   localparam logic [7:0] CHAR_SPACE = 8'h20;
   localparam logic [7:0] CHAR_END   = 8'h00;
endpackage

// File: rtl/scroll_rate_div.sv
module scroll_rate_div #(
   parameter int SPD_MIN  = 1,
   parameter int SPD_MAX  = 15,
   parameter int SPD_INIT = 8,
   parameter int UNIT_CYC = 262144
) (
   input  logic clk,
   input  logic rst,
   input  logic faster_i,
   input  logic slower_i,
   output logic tick_o
);
   localparam int SPD_W   = $clog2(SPD_MAX + 1);
   localparam int PER_W   = $clog2(SPD_MAX * UNIT_CYC + 1);
   localparam int UNIT_LG = $clog2(UNIT_CYC);
   localparam bit UNIT_P2 = ((UNIT_CYC & (UNIT_CYC - 1)) == 0);

   logic [SPD_W-1:0] speed_q;
   logic [PER_W-1:0] period;
   logic [PER_W-1:0] cnt_q;

   generate
      if (UNIT_P2) begin : g_shift
         assign period = PER_W'(speed_q) << UNIT_LG;
      end else begin : g_mult
         assign period = PER_W'(speed_q) * PER_W'(UNIT_CYC);
      end
   endgenerate

   assign tick_o = (cnt_q >= period - PER_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         speed_q <= SPD_W'(SPD_INIT);
         cnt_q   <= '0;
      end else begin
         if (faster_i && !slower_i && (speed_q > SPD_W'(SPD_MIN)))
            speed_q <= speed_q - SPD_W'(1);
         else if (slower_i && !faster_i && (speed_q < SPD_W'(SPD_MAX)))
            speed_q <= speed_q + SPD_W'(1);
         cnt_q <= tick_o ? '0 : cnt_q + PER_W'(1);
      end
   end
endmodule

// File: rtl/scroll_addr_seq.sv
module scroll_addr_seq
   import scroll_pkg::*;
#(
   parameter int          ADDR_W = 10,
   parameter int          CHAR_W = 8,
   parameter logic [CHAR_W-1:0] TERM = CHAR_W'(CHAR_END)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_i,
   input  logic [CHAR_W-1:0] data_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              rd_o,
   output logic              load_o
);
   localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

   scan_dir_e         dir_q, nxt_dir;
   logic [ADDR_W-1:0] addr_q, nxt_addr;
   logic              cap_q;
   logic              is_end;

   assign is_end = (data_i == TERM);
   assign load_o = cap_q && !is_end;
   assign addr_o = addr_q;

   always_comb begin
      nxt_addr = addr_q;
      nxt_dir  = dir_q;
      if (dir_q == SCAN_FWD) begin
         if (is_end) begin
            if (addr_q == '0) begin
               nxt_addr = '0;
            end else if (addr_q == ADDR_W'(1)) begin
               nxt_addr = '0;
               nxt_dir  = SCAN_REV;
            end else begin
               nxt_addr = addr_q - ADDR_W'(2);
               nxt_dir  = SCAN_REV;
            end
         end else if (addr_q == ADDR_LAST) begin
            nxt_addr = addr_q - ADDR_W'(1);
            nxt_dir  = SCAN_REV;
         end else begin
            nxt_addr = addr_q + ADDR_W'(1);
         end
      end else begin
         if (addr_q == '0) begin
            nxt_addr = ADDR_W'(1);
            nxt_dir  = SCAN_FWD;
         end else begin
            nxt_addr = addr_q - ADDR_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         dir_q  <= SCAN_FWD;
         rd_o   <= 1'b0;
         cap_q  <= 1'b0;
      end else begin
         rd_o  <= tick_i;
         cap_q <= rd_o;
         if (cap_q) begin
            addr_q <= nxt_addr;
            dir_q  <= nxt_dir;
         end
      end
   end
endmodule

// File: rtl/scroll_disp.sv
module scroll_disp #(
   parameter int          CHAR_W = 8,
   parameter logic [CHAR_W-1:0] BLANK = CHAR_W'(8'h20)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic [CHAR_W-1:0] char_i,
   output logic [CHAR_W-1:0] left_o,
   output logic [CHAR_W-1:0] right_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         left_o  <= BLANK;
         right_o <= BLANK;
      end else if (load_i) begin
         left_o  <= right_o;
         right_o <= char_i;
      end
   end
endmodule

// File: rtl/scroll_msg_ctrl.sv
module scroll_msg_ctrl
   import scroll_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int CHAR_W   = 8,
   parameter int SPD_MIN  = 1,
   parameter int SPD_MAX  = 15,
   parameter int SPD_INIT = 8,
   parameter int UNIT_CYC = 262144
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              faster_i,
   input  logic              slower_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_rd_o,
   input  logic [CHAR_W-1:0] mem_data_i,
   output logic [CHAR_W-1:0] left_char_o,
   output logic [CHAR_W-1:0] right_char_o
);
   localparam logic [CHAR_W-1:0] TERM  = CHAR_W'(CHAR_END);
   localparam logic [CHAR_W-1:0] BLANK = CHAR_W'(CHAR_SPACE);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end
   if (CHAR_W < 7) begin : g_bad_char
      $error("CHAR_W must hold an ASCII code");
   end
   if (SPD_MIN < 1 || SPD_MAX < SPD_MIN || SPD_INIT < SPD_MIN || SPD_INIT > SPD_MAX) begin : g_bad_spd
      $error("speed limits out of order");
   end
   if (UNIT_CYC * SPD_MIN < 2) begin : g_bad_unit
      $error("shortest step must span at least two cycles");
   end

   logic tick;
   logic load;

   scroll_rate_div #(
      .SPD_MIN(SPD_MIN), .SPD_MAX(SPD_MAX), .SPD_INIT(SPD_INIT), .UNIT_CYC(UNIT_CYC)
   ) rate_i (
      .clk(clk), .rst(rst), .faster_i(faster_i), .slower_i(slower_i), .tick_o(tick)
   );

   scroll_addr_seq #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .TERM(TERM)) seq_i (
      .clk(clk), .rst(rst), .tick_i(tick), .data_i(mem_data_i),
      .addr_o(mem_addr_o), .rd_o(mem_rd_o), .load_o(load)
   );

   scroll_disp #(.CHAR_W(CHAR_W), .BLANK(BLANK)) disp_i (
      .clk(clk), .rst(rst), .load_i(load), .char_i(mem_data_i),
      .left_o(left_char_o), .right_o(right_char_o)
   );
endmodule

// File: rtl/scroll_msg_ctrl_chk.sv
module scroll_msg_ctrl_chk #(
   parameter int ADDR_W = 10,
   parameter int CHAR_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_rd_o,
   input logic [CHAR_W-1:0] left_char_o,
   input logic [CHAR_W-1:0] right_char_o
);
   localparam logic [CHAR_W-1:0] TERM  = '0;
   localparam logic [CHAR_W-1:0] BLANK = CHAR_W'(8'h20);
   localparam logic [ADDR_W-1:0] UP1   = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] DN1   = '1;
   localparam logic [ADDR_W-1:0] DN2   = '1 - ADDR_W'(1);

   assert_reset_state_R1: assert property (@(posedge clk)
      $fell(rst) |-> (mem_addr_o == '0 && !mem_rd_o && left_char_o == BLANK && right_char_o == BLANK));

   assert_single_read_R2: assert property (@(posedge clk) disable iff (rst)
      mem_rd_o |=> !mem_rd_o);

   assert_end_hidden_R4: assert property (@(posedge clk) disable iff (rst)
      (left_char_o != TERM) && (right_char_o != TERM));

   assert_addr_move_R6: assert property (@(posedge clk) disable iff (rst)
      !$stable(mem_addr_o) |-> ((ADDR_W'(mem_addr_o - $past(mem_addr_o)) == UP1) ||
                                (ADDR_W'(mem_addr_o - $past(mem_addr_o)) == DN1) ||
                                (ADDR_W'(mem_addr_o - $past(mem_addr_o)) == DN2)));

   assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !$past(mem_rd_o, 2) |-> $stable(mem_addr_o));

   assert_disp_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !$past(mem_rd_o, 2) |-> ($stable(left_char_o) && $stable(right_char_o)));
endmodule

bind scroll_msg_ctrl scroll_msg_ctrl_chk #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) chk_i (
   .clk(clk), .rst(rst), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
   .left_char_o(left_char_o), .right_char_o(right_char_o)
);

// File: tb/scroll_msg_ctrl_tb_top.sv
module scroll_msg_ctrl_tb_top;
   localparam int AW   = 8;
   localparam int UNIT = 4;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          faster = 1'b0;
   logic          slower = 1'b0;
   logic [AW-1:0] addr;
   logic          rd;
   logic [7:0]    rdata = 8'h00;
   logic [7:0]    left_c, right_c;

   logic [7:0] mem [DEPTH];

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit finished = 0;

   int exp_addr, exp_speed, last_rd;
   bit exp_rev, skip_int;
   logic [7:0] exp_left, exp_right;
   string addr_tag;

   always #5 clk = ~clk;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rd) rdata <= mem[addr];
   end

   scroll_msg_ctrl #(.ADDR_W(AW), .CHAR_W(8), .UNIT_CYC(UNIT)) dut_i (
      .clk(clk), .rst(rst), .faster_i(faster), .slower_i(slower),
      .mem_addr_o(addr), .mem_rd_o(rd), .mem_data_i(rdata),
      .left_char_o(left_c), .right_char_o(right_c)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] rnd_char();
      return 8'(8'h21 + ($urandom % 94));
   endfunction

   task automatic load_msg(input int len);
      for (int i = 0; i < DEPTH; i++) mem[i] = (i < len) ? rnd_char() : 8'h00;
   endtask

   task automatic do_reset();
      rst = 1'b1; faster = 1'b0; slower = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      exp_addr = 0; exp_rev = 0; exp_left = 8'h20; exp_right = 8'h20;
      exp_speed = 8; skip_int = 1; addr_tag = "R1";
   endtask

   // cmd: 1 faster, 2 slower, 3 both
   task automatic cmd(input int kind);
      faster = kind[0]; slower = kind[1];
      if (kind == 1 && exp_speed > 1)  exp_speed--;
      if (kind == 2 && exp_speed < 15) exp_speed++;
      skip_int = 1;
      @(negedge clk);
      faster = 1'b0; slower = 1'b0;
   endtask

   task automatic step();
      int guard = 0;
      logic [7:0] d;
      do begin
         @(negedge clk);
         guard++;
      end while (!rd && guard < 400);
      chk(rd, "R2 read strobe missing", 0, 1);
      chk(addr == AW'(exp_addr), addr_tag, addr, exp_addr);
      if (!skip_int) chk(cyc - last_rd == exp_speed * UNIT, "R8 step period (R2)", cyc - last_rd, exp_speed * UNIT);
      last_rd = cyc; skip_int = 0;
      @(negedge clk);
      chk(!rd, "R2 strobe width", rd, 0);
      @(negedge clk);
      d = mem[exp_addr];
      if (!exp_rev) begin
         if (d == 8'h00) begin
            if (exp_addr == 0) begin addr_tag = "R5 end at 0"; end
            else if (exp_addr == 1) begin exp_addr = 0; exp_rev = 1; addr_tag = "R5 end at 1"; end
            else begin exp_addr -= 2; exp_rev = 1; addr_tag = "R5 turn A-2"; end
         end else begin
            exp_left = exp_right; exp_right = d;
            if (exp_addr == DEPTH - 1) begin exp_addr--; exp_rev = 1; addr_tag = "R7 top turn"; end
            else begin exp_addr++; addr_tag = "R3 forward"; end
         end
      end else begin
         if (d != 8'h00) begin exp_left = exp_right; exp_right = d; end
         if (exp_addr == 0) begin exp_addr = 1; exp_rev = 0; addr_tag = "R6 turn at 0"; end
         else begin exp_addr--; addr_tag = "R6 reverse"; end
      end
      chk(left_c == exp_left,  (d == 0) ? "R4 left held" : "R3 left shift", left_c, exp_left);
      chk(right_c == exp_right, (d == 0) ? "R4 right held" : "R3 right load", right_c, exp_right);
   endtask

   initial begin
      void'($urandom(32'd4242));
      load_msg(6);
      do_reset();
      @(negedge clk);
      chk(left_c == 8'h20 && right_c == 8'h20, "R1 blank display", {left_c, right_c}, 16'h2020);
      chk(addr == 0 && !rd, "R1 address and strobe", {addr, rd}, 0);
      repeat (20) step();

      // R8: ramp to floor, then ceiling
      for (int i = 0; i < 12; i++) begin step(); cmd(1); end
      repeat (4) step();
      for (int i = 0; i < 18; i++) begin step(); cmd(2); end
      repeat (3) step();
      step(); cmd(3);
      repeat (3) step();

      // R5 corners: length 0, 1, 2
      for (int len = 0; len < 3; len++) begin
         load_msg(len);
         do_reset();
         for (int i = 0; i < 8; i++) begin step(); if (i < 7) cmd(1); end
         repeat (6) step();
      end

      // R7: no end code anywhere
      for (int i = 0; i < DEPTH; i++) mem[i] = rnd_char();
      do_reset();
      for (int i = 0; i < 7; i++) begin step(); cmd(1); end
      repeat (DEPTH + 8) step();

      // random bounces with random speed commands
      for (int t = 0; t < 6; t++) begin
         load_msg(2 + int'($urandom % 29));
         do_reset();
         for (int i = 0; i < 40; i++) begin
            step();
            if ($urandom % 4 == 0) cmd(1 + int'($urandom % 3));
         end
      end

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule